// File: doc/BRIEF.md
# Triggered Video Luma Capture Controller

This block watches an 8-bit interleaved YUV 4:2:2 pixel bus coming from a video decoder. It runs on the decoder's line-locked clock. Two discrete inputs qualify the bus: a field sync and a line sync. A byte is image data only while both of them are high. At all other times the bus carries blanking.

The block does nothing until a vehicle-detect command rises. It then waits for the next field sync rising edge and captures exactly one interlaced frame: an odd field followed by an even field. From every active line it keeps only the luminance bytes. It emits each kept byte with a valid strobe, the byte's sample index within the line and an end-of-line flag, so downstream logic receives a grayscale stream. When the second field closes, the block pulses a frame-done output and returns to idle.

A field whose count of active lines differs from the configured value sets a sticky error flag. A command that stays high after a frame does not start a second frame. Only a fresh rising edge of the command does.

Top module: `luma_capture`

## Requirements
- R1: After reset, lumaValid, lineEnd, frameDone and fieldErr are 0.
- R2: No luma is emitted before a rising edge of detectCmd. A command held high across the end of a frame starts no new frame until it falls and rises again.
- R3: After arming, capture starts only at a rising edge of fieldSync. A field already in progress when the command rises is skipped in full.
- R4: While capturing, a byte is taken only when fieldSync and lineSync are both 1. Within each line the first active byte is chroma and bytes alternate chroma and luma (Cb, Y, Cr, Y), so the 2nd, 4th, ... active bytes are luma. Each luma byte appears on lumaData with lumaValid high one clock after it is sampled.
- R5: pixIndex is the luma sample's position in its line, starting at 0 and counting up by 1. Luma samples past PIX_PER_LINE in one line are dropped.
- R6: lineEnd is high together with lumaValid exactly on the sample whose pixIndex is PIX_PER_LINE-1, and at no other time.
- R7: Two fields are captured per trigger. frameDone is a single-cycle pulse in the second clock after the clock in which fieldSync is first seen low at the end of the second field.
- R8: fieldErr is set once a captured field ends with an active-line count other than LINES_PER_FIELD. It then stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Decoder line-locked clock |
| rstN | input | 1 | Active-low synchronous reset |
| vidData | input | DATA_W | Interleaved 4:2:2 pixel bus |
| fieldSync | input | 1 | Field active qualifier |
| lineSync | input | 1 | Line active qualifier |
| detectCmd | input | 1 | Vehicle-detect command; rising edge arms a capture |
| lumaValid | output | 1 | Strobe for a captured luma byte |
| lumaData | output | DATA_W | Captured luma byte |
| pixIndex | output | PIX_W | Index of the luma sample within its line |
| lineEnd | output | 1 | Last luma sample of a line |
| frameDone | output | 1 | One-cycle pulse after the second field |
| fieldErr | output | 1 | Sticky wrong-line-count flag |

## Verification
A byte-phase register out of step shows up on the first luma sample of the affected line as a chroma value on lumaData. A pixel counter that fails to clear shows a wrong pixIndex on the next line's first sample. A state machine in the wrong state shows either as luma from a field that should be skipped or as a missing or doubled frameDone. Either becomes visible within one field. A line counter fault surfaces on fieldErr at the end of the first field it corrupts.

// File: rtl/luma_capture_pkg.sv
package luma_capture_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_WAIT   = 3'd1,
    ST_FIELDA = 3'd2,
    ST_FIELDB = 3'd3,
    ST_DONE   = 3'd4
  } capState_t;

  // Strobes from the control to the datapath
  typedef struct packed {
    logic capEn;     // accept active bytes this cycle
    logic cntClear;  // restart the per-field line count
    logic cntCheck;  // compare the line count at field close
  } ctrlStrb_t;

  // Sync events from the datapath to the control
  typedef struct packed {
    logic fieldRise;
    logic fieldFall;
  } syncEv_t;

endpackage

// File: rtl/luma_capture_ctrl.sv
module luma_capture_ctrl
  import luma_capture_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      detectCmd,
  input  syncEv_t   ev,
  output ctrlStrb_t strb,
  output logic      frameDone
);

  capState_t state, stateNext;
  logic      detPrev;
  logic      detRise;

  assign detRise = detectCmd && !detPrev;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      detPrev <= 1'b0;
      state   <= ST_IDLE;
    end else begin
      detPrev <= detectCmd;
      state   <= stateNext;
    end
  end

  always_comb begin
    stateNext = state;
    case (state)
      ST_IDLE:   if (detRise)      stateNext = ST_WAIT;
      ST_WAIT:   if (ev.fieldRise) stateNext = ST_FIELDA;
      ST_FIELDA: if (ev.fieldFall) stateNext = ST_FIELDB;
      ST_FIELDB: if (ev.fieldFall) stateNext = ST_DONE;
      ST_DONE:                     stateNext = ST_IDLE;
      default:                     stateNext = ST_IDLE;
    endcase
  end

  always_comb begin
    strb.capEn    = (state == ST_FIELDA) || (state == ST_FIELDB) ||
                    ((state == ST_WAIT) && ev.fieldRise);
    strb.cntClear = ((state == ST_WAIT) && ev.fieldRise) ||
                    ((state == ST_FIELDA) && ev.fieldFall);
    strb.cntCheck = ((state == ST_FIELDA) || (state == ST_FIELDB)) && ev.fieldFall;
  end

  assign frameDone = (state == ST_DONE);

  // frame completion is a single-cycle pulse
  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rstN)
    frameDone |=> !frameDone);

  // the first field always hands over to the second field
  assert_field_order_R7: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_FIELDA) |=> (state == ST_FIELDA || state == ST_FIELDB));

  // a capture cannot begin while the idle state sees no command edge
  assert_no_start_R2: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && !detRise) |=> (state == ST_IDLE));

endmodule

// File: rtl/luma_capture_dp.sv
module luma_capture_dp
  import luma_capture_pkg::*;
#(
  parameter int DATA_W          = 8,
  parameter int PIX_PER_LINE    = 720,
  parameter int LINES_PER_FIELD = 286,
  parameter int PIX_W           = $clog2(PIX_PER_LINE + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] vidData,
  input  logic              fieldSync,
  input  logic              lineSync,
  input  ctrlStrb_t         strb,
  output syncEv_t           ev,
  output logic              lumaValid,
  output logic [DATA_W-1:0] lumaData,
  output logic [PIX_W-1:0]  pixIndex,
  output logic              lineEnd,
  output logic              fieldErr
);

  localparam int LINE_W = $clog2(LINES_PER_FIELD + 2);
  localparam logic [PIX_W-1:0]  PIX_LIM  = PIX_W'(PIX_PER_LINE);
  localparam logic [PIX_W-1:0]  PIX_LAST = PIX_W'(PIX_PER_LINE - 1);
  localparam logic [LINE_W-1:0] LINE_EXP = LINE_W'(LINES_PER_FIELD);
  localparam logic [LINE_W-1:0] LINE_MAX = {LINE_W{1'b1}};

  logic              fieldPrev, actPrev;
  logic              bytePhase;
  logic [PIX_W-1:0]  lumaNo;
  logic [LINE_W-1:0] lineCnt;
  logic              active, takeLuma, lineStart;

  assign active       = fieldSync && lineSync;
  assign ev.fieldRise = fieldSync && !fieldPrev;
  assign ev.fieldFall = !fieldSync && fieldPrev;
  assign takeLuma     = strb.capEn && active && bytePhase && (lumaNo < PIX_LIM);
  assign lineStart    = strb.capEn && active && !actPrev;

  // byte phase and per-line luma position
  always_ff @(posedge clk) begin
    if (!rstN) begin
      fieldPrev <= 1'b0;
      actPrev   <= 1'b0;
      bytePhase <= 1'b0;
      lumaNo    <= '0;
    end else begin
      fieldPrev <= fieldSync;
      actPrev   <= active;
      bytePhase <= active ? !bytePhase : 1'b0;
      if (!active)
        lumaNo <= '0;
      else if (bytePhase && lumaNo < PIX_LIM)
        lumaNo <= lumaNo + 1'b1;
    end
  end

  // output stage
  always_ff @(posedge clk) begin
    if (!rstN) begin
      lumaValid <= 1'b0;
      lumaData  <= '0;
      pixIndex  <= '0;
      lineEnd   <= 1'b0;
    end else begin
      lumaValid <= takeLuma;
      lineEnd   <= takeLuma && (lumaNo == PIX_LAST);
      if (takeLuma) begin
        lumaData <= vidData;
        pixIndex <= lumaNo;
      end
    end
  end

  // per-field line count and sticky error
  always_ff @(posedge clk) begin
    if (!rstN) begin
      lineCnt  <= '0;
      fieldErr <= 1'b0;
    end else begin
      if (strb.cntCheck && lineCnt != LINE_EXP)
        fieldErr <= 1'b1;
      if (strb.cntClear)
        lineCnt <= lineStart ? LINE_W'(1) : '0;
      else if (lineStart && lineCnt != LINE_MAX)
        lineCnt <= lineCnt + 1'b1;
    end
  end

  // a luma strobe always follows a cycle with both syncs high
  assert_valid_active_R4: assert property (@(posedge clk) disable iff (!rstN)
    lumaValid |-> $past(fieldSync && lineSync));

  // the sample index never leaves the line
  assert_pix_range_R5: assert property (@(posedge clk) disable iff (!rstN)
    lumaValid |-> (pixIndex < PIX_LIM));

  // end of line only marks a valid final sample
  assert_end_last_R6: assert property (@(posedge clk) disable iff (!rstN)
    lineEnd |-> (lumaValid && pixIndex == PIX_LAST));

  // the error flag never clears once set
  assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rstN)
    fieldErr |=> fieldErr);

endmodule

// File: rtl/luma_capture.sv
module luma_capture
  import luma_capture_pkg::*;
#(
  parameter int DATA_W          = 8,
  parameter int PIX_PER_LINE    = 720,
  parameter int LINES_PER_FIELD = 286,
  localparam int PIX_W          = $clog2(PIX_PER_LINE + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] vidData,
  input  logic              fieldSync,
  input  logic              lineSync,
  input  logic              detectCmd,
  output logic              lumaValid,
  output logic [DATA_W-1:0] lumaData,
  output logic [PIX_W-1:0]  pixIndex,
  output logic              lineEnd,
  output logic              frameDone,
  output logic              fieldErr
);

  ctrlStrb_t strb;
  syncEv_t   ev;

  luma_capture_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .detectCmd (detectCmd),
    .ev        (ev),
    .strb      (strb),
    .frameDone (frameDone)
  );

  luma_capture_dp #(
    .DATA_W          (DATA_W),
    .PIX_PER_LINE    (PIX_PER_LINE),
    .LINES_PER_FIELD (LINES_PER_FIELD),
    .PIX_W           (PIX_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .vidData   (vidData),
    .fieldSync (fieldSync),
    .lineSync  (lineSync),
    .strb      (strb),
    .ev        (ev),
    .lumaValid (lumaValid),
    .lumaData  (lumaData),
    .pixIndex  (pixIndex),
    .lineEnd   (lineEnd),
    .fieldErr  (fieldErr)
  );

endmodule

// File: tb/luma_capture_tb.sv
`timescale 1ns/100ps
module luma_capture_tb;

  localparam int DW    = 8;
  localparam int PIX   = 8;
  localparam int LINES = 3;
  localparam int PW    = $clog2(PIX + 1);

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [DW-1:0] vidData = '0;
  logic          fieldSync = 1'b0;
  logic          lineSync = 1'b0;
  logic          detectCmd = 1'b0;
  logic          lumaValid, lineEnd, frameDone, fieldErr;
  logic [DW-1:0] lumaData;
  logic [PW-1:0] pixIndex;

  always #2.5 clk = ~clk;

  luma_capture #(.DATA_W(DW), .PIX_PER_LINE(PIX), .LINES_PER_FIELD(LINES)) u_dut (
    .clk(clk), .rstN(rstN), .vidData(vidData), .fieldSync(fieldSync),
    .lineSync(lineSync), .detectCmd(detectCmd), .lumaValid(lumaValid),
    .lumaData(lumaData), .pixIndex(pixIndex), .lineEnd(lineEnd),
    .frameDone(frameDone), .fieldErr(fieldErr)
  );

  int nChecks = 0;
  int nFails  = 0;
  int doneCnt = 0;
  int strayCnt = 0;
  int seed = 0;
  logic prevDone = 1'b0;
  logic finished = 1'b0;

  // expected luma stream, built from the stimulus
  int expData[$];
  int expPix[$];
  int expEnd[$];

  task automatic check(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // compared on every clock, away from the active edge
  always @(negedge clk) begin
    if (rstN && !finished) begin
      if (lumaValid) begin
        if (expData.size() == 0) begin
          strayCnt++;
          check("R4 unexpected luma strobe", 1, 0);
        end else begin
          check("R4 luma data", int'(lumaData), expData.pop_front());
          check("R5 pixel index", int'(pixIndex), expPix.pop_front());
          check("R6 line end", int'(lineEnd), expEnd.pop_front());
        end
      end else begin
        check("R6 line end without strobe", int'(lineEnd), 0);
      end
      if (frameDone) begin
        doneCnt++;
        check("R7 frame done width", int'(prevDone), 0);
      end
      prevDone <= frameDone;
    end
  end

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic blank(input int n);
    for (int i = 0; i < n; i++) begin
      lineSync = 1'b0;
      tick();
    end
  endtask

  task automatic sendLine(input int nBytes, input bit cap);
    for (int k = 0; k < nBytes; k++) begin
      lineSync = 1'b1;
      vidData  = DW'((seed * 32 + k) & 255);
      if (cap && (k % 2 == 1) && (k / 2 < PIX)) begin
        expData.push_back(int'(vidData));
        expPix.push_back(k / 2);
        expEnd.push_back((k / 2 == PIX - 1) ? 1 : 0);
      end
      tick();
    end
    seed++;
    lineSync = 1'b0;
    blank(3);
  endtask

  task automatic sendField(input int nLines, input bit cap);
    fieldSync = 1'b1;
    blank(2);
    for (int l = 0; l < nLines; l++) sendLine(2 * PIX, cap);
    fieldSync = 1'b0;
    blank(4);
  endtask

  initial begin
    #100000;
    if (!finished) begin
      finished = 1'b1;
      nChecks++;
      nFails++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    blank(5);
    rstN = 1'b1;
    #1;
    // R1 reset state
    check("R1 lumaValid after reset", int'(lumaValid), 0);
    check("R1 lineEnd after reset", int'(lineEnd), 0);
    check("R1 frameDone after reset", int'(frameDone), 0);
    check("R1 fieldErr after reset", int'(fieldErr), 0);
    tick();

    // R2 fields with no command produce nothing
    sendField(LINES, 0);
    sendField(LINES, 0);
    check("R2 no luma without command", strayCnt, 0);

    // normal triggered frame
    detectCmd = 1'b1;
    blank(3);
    sendField(LINES, 1);
    sendField(LINES, 1);
    blank(4);
    check("R7 one frame done per trigger", doneCnt, 1);
    check("R4 expected stream drained", expData.size(), 0);
    check("R8 no error on good frame", int'(fieldErr), 0);

    // R2 command still held: no new frame
    sendField(LINES, 0);
    sendField(LINES, 0);
    blank(4);
    check("R2 held command starts nothing", strayCnt, 0);
    check("R2 no extra frame done", doneCnt, 1);

    // R3 arm in the middle of a field: that field is skipped
    detectCmd = 1'b0;
    blank(4);
    fieldSync = 1'b1;
    blank(2);
    sendLine(2 * PIX, 0);
    detectCmd = 1'b1;
    sendLine(2 * PIX, 0);
    fieldSync = 1'b0;
    blank(4);
    sendField(LINES, 1);
    sendField(LINES, 1);
    blank(4);
    check("R3 partial field skipped", strayCnt, 0);
    check("R3 frame after field start", doneCnt, 2);
    check("R3 expected stream drained", expData.size(), 0);
    check("R8 still clear", int'(fieldErr), 0);

    // R5 over-long line and R8 short field
    detectCmd = 1'b0;
    blank(3);
    detectCmd = 1'b1;
    blank(3);
    fieldSync = 1'b1;
    blank(2);
    sendLine(2 * PIX, 1);
    sendLine(2 * PIX + 6, 1);
    fieldSync = 1'b0;
    blank(4);
    check("R8 short field flags error", int'(fieldErr), 1);
    sendField(LINES, 1);
    blank(4);
    check("R5 extra samples dropped", expData.size(), 0);
    check("R7 frame done after second field", doneCnt, 3);
    check("R8 error stays set", int'(fieldErr), 1);
    check("R4 no stray luma overall", strayCnt, 0);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule